// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it holds off all traffic for the power-up settling time. It then runs a fixed number of warm-up refresh cycles and raises a ready flag that lets the access controller begin normal reads and writes. From then on, a free-running interval timer adds one refresh to a small owed count at every interval. Each owed refresh is requested from the access controller through a request/grant handshake.

Every refresh is of the column-strobe-first kind. Once granted, the sequencer drives the row strobe, the column strobe and the write strobe itself, so no address is needed; the DRAM's own row counter supplies the row. All strobe widths and intervals are given in nanoseconds and turned into clock counts from the clock-period parameter.

The owed count saturates at a small limit. A long burst of page-mode traffic can hold the bus for several intervals without losing refreshes. When the grant returns, the sequencer repeats cycles back to back until the count is paid off.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_n is low, ras_n, cas_n and we_n are 1 and ref_req, ref_busy and mem_ready are 0.
- R2: After reset is released, ref_req stays 0 and no strobe moves for exactly ceil(INIT_WAIT_NS/CLK_NS) clock edges (10000 at the defaults); ref_req is 1 after that edge.
- R3: A refresh cycle starts only from idle while ref_req and ref_gnt are both 1. ref_gnt has no effect while ref_req is 0. While ref_gnt is 0, no strobe moves.
- R4: cas_n goes low at least one cycle before ras_n falls and stays low for the whole time ras_n is low. Both rise on the same edge. we_n is 1 whenever ras_n falls.
- R5: ras_n stays low for at least 3 cycles (60 ns at 20 ns per clock). Between refreshes, ras_n stays high for at least 3 cycles.
- R6: mem_ready rises only when the 8th warm-up refresh completes, with ras_n high. ref_req is 0 at that point. mem_ready then stays 1 until reset.
- R7: Once ready, one refresh is owed every floor(REFRESH_NS/CLK_NS) cycles (780 at the defaults). With ref_gnt held at 1, consecutive ras_n falls are exactly 780 cycles apart.
- R8: The owed count saturates at OWED_MAX (7). When the grant returns after a long withholding, exactly 7 refreshes run with ras_n falls 9 cycles apart, and then ref_req drops to 0.
- R9: An asynchronous reset in the middle of a refresh returns all strobes high and mem_ready low at once. The power-up wait then starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller grants the DRAM bus to the sequencer |
| ref_req | output | 1 | At least one refresh (warm-up or periodic) is owed |
| ref_busy | output | 1 | Sequencer is driving the strobes; the controller keeps off the bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| mem_ready | output | 1 | Power-up wait and warm-up refreshes are complete |

## Verification
A corrupted phase counter shows up as a wrong ras_n low width or a wrong column-strobe lead. This is visible at the edges of the very first refresh. A wrong interval timer or owed count does not show inside a single cycle. It appears at the next ras_n fall as a spacing other than 780 cycles, or after a withheld grant as a catch-up burst of the wrong length. A wrong warm-up count moves the rise of mem_ready away from the 8th completed cycle.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_NS         = 20,
  parameter int INIT_WAIT_NS   = 200000,
  parameter int REFRESH_NS     = 15600,
  parameter int INIT_REFRESHES = 8,
  parameter int OWED_MAX       = 7,
  parameter int TCSR_NS        = 10,
  parameter int TCHR_NS        = 10,
  parameter int TRAS_NS        = 60,
  parameter int TRP_NS         = 40,
  parameter int TRC_NS         = 110,
  parameter int TRPC_NS        = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_busy,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic mem_ready
);

  localparam int INIT_CYC = (INIT_WAIT_NS + CLK_NS - 1) / CLK_NS;
  localparam int REF_CYC  = REFRESH_NS / CLK_NS;
  localparam int CSR_RAW  = (TCSR_NS + CLK_NS - 1) / CLK_NS;
  localparam int GAP_RAW  = (TRPC_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_A    = (TRAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_B    = (TCHR_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_RAW  = (RAS_A > RAS_B) ? RAS_A : RAS_B;
  localparam int CSR_CYC  = (CSR_RAW < 1) ? 1 : CSR_RAW;
  localparam int GAP_CYC  = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int RAS_CYC  = (RAS_RAW < 1) ? 1 : RAS_RAW;
  localparam int RP_A     = (TRP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP_B     = (TRC_NS + CLK_NS - 1) / CLK_NS - RAS_CYC;
  localparam int RP_RAW   = (RP_A > RP_B) ? RP_A : RP_B;
  localparam int RP_CYC   = (RP_RAW < 1) ? 1 : RP_RAW;
  localparam int PH_M1    = (CSR_CYC > GAP_CYC) ? CSR_CYC : GAP_CYC;
  localparam int PH_M2    = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
  localparam int PH_MAX   = (PH_M1 > PH_M2) ? PH_M1 : PH_M2;
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int TMR_MAX  = (INIT_CYC > REF_CYC) ? INIT_CYC : REF_CYC;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int OWED_W   = $clog2(OWED_MAX + 1);
  localparam int INIT_W   = $clog2(INIT_REFRESHES + 1);
  localparam int RUN_W    = PH_W + 2;

  localparam logic [TMR_W-1:0]  INIT_LAST = TMR_W'(INIT_CYC - 1);
  localparam logic [TMR_W-1:0]  REF_LAST  = TMR_W'(REF_CYC - 1);
  localparam logic [OWED_W-1:0] OWED_TOP  = OWED_W'(OWED_MAX);

  typedef enum logic [2:0] {ST_POWER, ST_IDLE, ST_GAP, ST_CAS, ST_RAS, ST_PRE} st_t;

  st_t              st;
  logic [PH_W-1:0]  ph;
  logic [TMR_W-1:0] tmr;
  logic [OWED_W-1:0] owed;
  logic [INIT_W-1:0] init_left;

  logic tick, done, pend, ph_end;

  assign ph_end = (ph == '0);
  assign done   = (st == ST_PRE) && ph_end;
  assign tick   = mem_ready && (tmr == REF_LAST);
  assign pend   = mem_ready ? (owed != '0) : ((st != ST_POWER) && (init_left != '0));

  assign ref_req  = pend;
  assign ref_busy = (st != ST_POWER) && (st != ST_IDLE);
  assign ras_n    = (st != ST_RAS);
  assign cas_n    = !((st == ST_CAS) || (st == ST_RAS));
  assign we_n     = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_POWER;
      ph <= '0;
    end else begin
      case (st)
        ST_POWER: if (tmr == INIT_LAST) st <= ST_IDLE;
        ST_IDLE: if (pend && ref_gnt) begin
          st <= ST_GAP;
          ph <= PH_W'(GAP_CYC - 1);
        end
        ST_GAP: if (ph_end) begin
          st <= ST_CAS;
          ph <= PH_W'(CSR_CYC - 1);
        end else ph <= ph - 1'b1;
        ST_CAS: if (ph_end) begin
          st <= ST_RAS;
          ph <= PH_W'(RAS_CYC - 1);
        end else ph <= ph - 1'b1;
        ST_RAS: if (ph_end) begin
          st <= ST_PRE;
          ph <= PH_W'(RP_CYC - 1);
        end else ph <= ph - 1'b1;
        ST_PRE: if (ph_end) st <= ST_IDLE;
                else ph <= ph - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else if (st == ST_POWER) tmr <= (tmr == INIT_LAST) ? '0 : tmr + 1'b1;
    else if (mem_ready) tmr <= tick ? '0 : tmr + 1'b1;
    else tmr <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed      <= '0;
      init_left <= INIT_W'(INIT_REFRESHES);
      mem_ready <= 1'b0;
    end else if (mem_ready) begin
      if (tick && !done && owed != OWED_TOP) owed <= owed + 1'b1;
      else if (done && !tick) owed <= owed - 1'b1;
    end else if (done) begin
      init_left <= init_left - 1'b1;
      if (init_left == INIT_W'(1)) mem_ready <= 1'b1;
    end
  end

  logic [RUN_W-1:0] lo_run, hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lo_run <= ras_n ? '0 : ((&lo_run) ? lo_run : lo_run + 1'b1);
      hi_run <= !ras_n ? '0 : ((&hi_run) ? hi_run : hi_run + 1'b1);
    end
  end

  assert_power_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POWER) |-> (!ref_req && ras_n && cas_n));
  assert_no_grantless_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_busy && !ref_gnt) |=> !ref_busy);
  assert_idle_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_busy |-> (ras_n && cas_n));
  assert_cas_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == 1'b0));
  assert_cas_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_run >= RUN_W'(RAS_CYC)));
  assert_ras_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_run >= RUN_W'(RP_CYC)));
  assert_ready_after_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> ($past(st) == ST_PRE));
  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> mem_ready);

endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int INIT_EXP = 200000 / 20;
  localparam int REF_EXP  = 15600 / 20;
  localparam int B2B      = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_busy, ras_n, cas_n, we_n, mem_ready;

  dram_refresh_seq uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_busy(ref_busy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .mem_ready(mem_ready)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push_exp(input int spacing, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(spacing);
  endtask

  int cyc = 0, last_fall = 0, falls = 0, lo = 0, hi = 0, ready_cnt = 0;
  bit p_ras = 1'b1, p_cas = 1'b1, cas_ok = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      p_ras = 1'b1; p_cas = 1'b1; lo = 0; hi = 0; ready_cnt = 0; cas_ok = 1'b1;
    end else begin
      cyc++;
      if (mem_ready) ready_cnt++;
      if (p_ras && !ras_n) begin
        falls++;
        chk(p_cas == 1'b0, "R4 cas low before ras fall", p_cas, 0);
        chk(we_n == 1'b1, "R4 we_n high at ras fall", we_n, 1);
        chk(hi >= 3, "R5 ras precharge cycles", hi, 3);
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected refresh", falls, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          if (e >= 0) chk(cyc - last_fall == e, "R7/R8 ras fall spacing", cyc - last_fall, e);
        end
        last_fall = cyc;
        cas_ok = 1'b1;
      end
      if (!ras_n && cas_n) cas_ok = 1'b0;
      if (!p_ras && ras_n) begin
        chk(lo >= 3, "R5 ras low cycles", lo, 3);
        chk(cas_ok && cas_n, "R4 cas low throughout and rises with ras", cas_n, 1);
      end
      if (ras_n) begin hi++; lo = 0; end else begin lo++; hi = 0; end
      p_ras = ras_n; p_cas = cas_n;
    end
  end

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    int n, f0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !ref_busy && !mem_ready, "R1 flags low in reset",
        {ref_req, ref_busy, mem_ready}, 0);
    rst_n = 1'b1;

    n = 0;
    while (!ref_req && n < 20000) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk(n == INIT_EXP, "R2 power-up wait length", n, INIT_EXP);
    chk(falls == 0, "R2 no strobes during wait", falls, 0);

    repeat (40) @(negedge clk);
    chk(falls == 0 && ref_req, "R3 no cycle without grant", falls, 0);

    push_exp(-1, 1);
    push_exp(B2B, 7);
    ref_gnt = 1'b1;
    n = 0;
    while (!mem_ready && n < 1000) begin @(negedge clk); n++; end
    chk(falls == 8, "R6 refreshes before ready", falls, 8);
    chk(ras_n && !ref_req, "R6 idle at ready", {ras_n, ref_req}, 2);

    push_exp(-1, 1);
    push_exp(REF_EXP, 3);
    n = 0;
    while (falls < 12 && n < 5000) begin @(negedge clk); n++; end
    chk(falls == 12, "R7 periodic refreshes seen", falls, 12);
    while (ref_busy) @(negedge clk);
    chk(mem_ready, "R6 ready stays high", mem_ready, 1);

    ref_gnt = 1'b0;
    f0 = falls;
    repeat (10 * REF_EXP) @(negedge clk);
    chk(falls == f0, "R3 grant withheld keeps strobes idle", falls - f0, 0);
    chk(ref_req, "R8 owed refreshes kept", ref_req, 1);
    while (ready_cnt % REF_EXP != 100) @(negedge clk);
    push_exp(-1, 1);
    push_exp(B2B, 6);
    ref_gnt = 1'b1;
    n = 0;
    while (ref_req && n < 2000) begin @(negedge clk); n++; end
    chk(falls - f0 == 7, "R8 catch-up burst length", falls - f0, 7);

    f0 = falls;
    repeat (300) @(negedge clk);
    chk(falls == f0 && !ref_req, "R3 grant ignored without request", falls - f0, 0);

    push_exp(-1, 1);
    n = 0;
    while (cas_n && n < 2000) begin @(negedge clk); n++; end
    rst_n = 1'b0;
    #1;
    chk(ras_n && cas_n && !ref_busy, "R9 strobes released by reset", {ras_n, cas_n, ref_busy}, 6);
    chk(!mem_ready && !ref_req, "R9 ready cleared by reset", {mem_ready, ref_req}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    f0 = falls;
    repeat (500) @(negedge clk);
    chk(!ref_req && falls == f0, "R9 power-up wait restarts", ref_req, 0);
    finish_run();
  end
endmodule